// File: doc/BRIEF.md
# Single-Bank Prioritised Interrupt Handler

This block collects 32 interrupt lines into two prioritised requests toward a processor: a normal request and a fast request. Every line has its own configuration word. The word selects edge or level sensing, chooses which of the two requests the line feeds, and sets a 5-bit priority. Inputs are active high. Each input is brought into the clock domain through a two-flop synchronizer, and the result is recorded in a pending register. A mask register then gates the pending bits.

Each request path holds an arming flag. While the path is armed and at least one unmasked line steered to it is pending, the path latches the winning line index and raises its request. The request stays up until software acknowledges it through the control register, which also re-arms the path. Software reads the winning index from an active-code register. For an edge-sensed line, that read also retires the pending bit. Software can also inject an interrupt through a software-set register.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF. The pending register, every line configuration word and both active-code registers read 0. Both request outputs are low.
- R2: The configuration word of line n sits at byte offset 0x1C+4n. Its bit 0 steers the line to the fast path (1) or the normal path (0). Bit 1 selects level (1) or edge (0) sensing. Bits [6:2] hold the priority. The word reads back as written in those bits. The control register (0x18), the software-set register (0x9C) and unmapped offsets such as 0x08 read 0.
- R3: An edge-sensed line sets its pending bit (register at 0x00) only on a 0-to-1 change of its synchronized input. The bit stays set when the input is removed, and holding the input high does not set it again.
- R4: A level-sensed line has its pending bit set on every cycle its synchronized input is high. The bit is cleared when the input falls.
- R5: A write to the pending register ANDs the pending bits with the written data. Bits of level-sensed lines whose input is still high are kept.
- R6: Candidates are the lines that are pending, unmasked and steered to the path. The candidate with the numerically lowest priority wins. Among equal priorities, the highest line index wins.
- R7: An armed path with a candidate latches the winner's index and raises its request (irq_req for the normal path, fiq_req for the fast path) one cycle later. The request holds until a control-register write with bit 0 (normal) or bit 1 (fast) set. That write drops the request in the next cycle and re-arms the path.
- R8: The normal code register (0x10) and the fast code register (0x14) return the latched index. A read of one of them clears that line's pending bit if the line is edge-sensed and leaves it unchanged if the line is level-sensed. Writes to either code register have no effect.
- R9: A write to the software-set register injects only the lowest set data bit, as an input assertion on that line. The pending bit is set if the line is level-sensed or its input is currently low.
- R10: An input change applied before clock edge E1 reaches the pending register at edge E3, after passing through the two synchronizer flops.
- R11: The mask register (0x04, 1 = masked) blocks masked lines from both paths. Clearing a mask bit of a pending line while the path is armed raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Active-high interrupt inputs |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (triggers read side effects) |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_req | output | 1 | Normal-path request |
| fiq_req | output | 1 | Fast-path request |

## Verification
The assertions take for granted that a read strobe and a write strobe never occur in the same cycle. They also take for granted that every bus address is word aligned. The bench drives reads and writes in separate cycles at aligned offsets only. Its random rounds always steer one unmasked, asserted line to each path, so every code read returns a freshly latched winner instead of a stale index.

// File: rtl/ihb_pkg.sv
`timescale 1ns/1ps
package ihb_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 5;
  localparam int CFG_W  = PRIO_W + 2;

  localparam logic [ADDR_W-1:0] A_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] A_NCODE = 8'h10;
  localparam logic [ADDR_W-1:0] A_FCODE = 8'h14;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h18;
  localparam logic [ADDR_W-1:0] A_CFG0  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_SWSET = 8'h9C;

  // packed so that bit 0 = steer, bit 1 = sense, [6:2] = priority
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/ihb_sync.sv
`timescale 1ns/1ps
module ihb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/ihb_arbiter.sv
`timescale 1ns/1ps
module ihb_arbiter #(
  parameter int N     = 32,
  parameter int PW    = 5,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            any,
  output logic [IDX_W-1:0] win
);
  logic [PW-1:0] best;

  // ascending scan with <= : equal priority resolves to the higher index
  always_comb begin
    any  = 1'b0;
    best = '1;
    win  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || prio[i*PW +: PW] <= best)) begin
        any  = 1'b1;
        best = prio[i*PW +: PW];
        win  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ihb_path.sv
`timescale 1ns/1ps
module ihb_path #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             any,
  input  logic [IDX_W-1:0] win,
  output logic             req,
  output logic [IDX_W-1:0] code
);
  logic             armed_q, armed_n;
  logic             req_q, req_n;
  logic [IDX_W-1:0] code_q, code_n;

  always_comb begin
    armed_n = armed_q;
    req_n   = req_q;
    code_n  = code_q;
    if (ack) begin
      req_n   = 1'b0;
      armed_n = 1'b1;
    end else if (armed_q && any) begin
      req_n   = 1'b1;
      code_n  = win;
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      armed_q <= armed_n;
      req_q   <= req_n;
      code_q  <= code_n;
    end
  end

  assign req  = req_q;
  assign code = code_q;
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import ihb_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_req,
  output logic               fiq_req
);
  localparam int IDX_W = $clog2(N_LINES);

  // ---------------- input conditioning ----------------
  logic [N_LINES-1:0] in_s, in_d;
  ihb_sync #(.W(N_LINES)) u_sync (.clk(clk), .rst_n(rst_n), .d(irq_in), .q(in_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_d <= '0;
    else        in_d <= in_s;
  end

  // ---------------- address decode ----------------
  logic [ADDR_W-1:0] cfg_off, cfg_word;
  logic [IDX_W-1:0]  cfg_idx;
  logic              cfg_hit;
  logic sel_pend, sel_mask, sel_ncode, sel_fcode, sel_ctrl, sel_swset;

  assign sel_pend  = (bus_addr == A_PEND);
  assign sel_mask  = (bus_addr == A_MASK);
  assign sel_ncode = (bus_addr == A_NCODE);
  assign sel_fcode = (bus_addr == A_FCODE);
  assign sel_ctrl  = (bus_addr == A_CTRL);
  assign sel_swset = (bus_addr == A_SWSET);
  assign cfg_off   = bus_addr - A_CFG0;
  assign cfg_word  = {2'b00, cfg_off[ADDR_W-1:2]};
  assign cfg_idx   = cfg_word[IDX_W-1:0];
  assign cfg_hit   = (bus_addr >= A_CFG0) && (cfg_word < ADDR_W'(N_LINES)) &&
                     (cfg_off[1:0] == 2'b00);

  // ---------------- per-line configuration ----------------
  line_cfg_t           cfg_q [N_LINES];
  logic [N_LINES-1:0]  lvl_vec, fast_vec;
  logic [N_LINES*PRIO_W-1:0] prio_flat;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic cfg_we;
    assign cfg_we = bus_wr && cfg_hit && (cfg_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (cfg_we) cfg_q[g] <= line_cfg_t'(bus_wdata[CFG_W-1:0]);
    end
    assign lvl_vec[g]                   = cfg_q[g].level;
    assign fast_vec[g]                  = cfg_q[g].fast;
    assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g].prio;
  end

  // ---------------- mask ----------------
  logic [N_LINES-1:0] mask_q;
  logic               mask_we;
  assign mask_we = bus_wr && sel_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= bus_wdata[N_LINES-1:0];
  end

  // ---------------- pending ----------------
  logic [N_LINES-1:0] pend_q, pend_n;
  logic [N_LINES-1:0] rise, fall, sw_bit, set_vec;
  logic [IDX_W-1:0]   ncode, fcode;
  logic               pend_en;

  assign rise   = in_s & ~in_d;
  assign fall   = ~in_s & in_d;
  assign sw_bit = (bus_wr && sel_swset) ?
                  (bus_wdata[N_LINES-1:0] & (~bus_wdata[N_LINES-1:0] + N_LINES'(1))) : '0;
  assign set_vec = (rise & ~lvl_vec) | (in_s & lvl_vec) | (sw_bit & (lvl_vec | ~in_s));
  assign pend_en = 1'b1;

  always_comb begin
    pend_n = pend_q & ~(fall & lvl_vec);
    if (bus_wr && sel_pend)
      pend_n = pend_n & (bus_wdata[N_LINES-1:0] | (in_s & lvl_vec));
    if (bus_rd && sel_ncode && !lvl_vec[ncode]) pend_n[ncode] = 1'b0;
    if (bus_rd && sel_fcode && !lvl_vec[fcode]) pend_n[fcode] = 1'b0;
    pend_n = pend_n | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_n;
  end

  // ---------------- two request paths ----------------
  logic [1:0]       path_req;
  logic [IDX_W-1:0] path_code [2];

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [N_LINES-1:0] cand;
    logic               any;
    logic [IDX_W-1:0]   win;
    logic               ack;
    assign cand = pend_q & ~mask_q & ((p == 1) ? fast_vec : ~fast_vec);
    assign ack  = bus_wr && sel_ctrl && bus_wdata[p];

    ihb_arbiter #(.N(N_LINES), .PW(PRIO_W), .IDX_W(IDX_W)) u_arb (
      .cand(cand), .prio(prio_flat), .any(any), .win(win)
    );
    ihb_path #(.IDX_W(IDX_W)) u_path (
      .clk(clk), .rst_n(rst_n), .ack(ack), .any(any), .win(win),
      .req(path_req[p]), .code(path_code[p])
    );
  end

  assign ncode   = path_code[0];
  assign fcode   = path_code[1];
  assign irq_req = path_req[0];
  assign fiq_req = path_req[1];

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (sel_pend)       bus_rdata = DATA_W'(pend_q);
    else if (sel_mask)  bus_rdata = DATA_W'(mask_q);
    else if (sel_ncode) bus_rdata = DATA_W'(ncode);
    else if (sel_fcode) bus_rdata = DATA_W'(fcode);
    else if (cfg_hit)   bus_rdata = DATA_W'(cfg_q[cfg_idx]);
  end
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk
  import ihb_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq_req,
  input logic               fiq_req,
  input logic [IDX_W-1:0]   ncode,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] in_s,
  input logic [N_LINES-1:0] lvl
);
  logic ack_n, ack_f;
  assign ack_n = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign ack_f = bus_wr && (bus_addr == A_CTRL) && bus_wdata[1];

  // R7: request persists until acknowledged
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack_n |=> irq_req);

  // R7: acknowledge drops the normal request
  a_r7_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |=> !irq_req);

  // R7: acknowledge drops the fast request
  a_r7_ack_drops_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    ack_f |=> !fiq_req);

  // R7: latched code frozen while request is up
  a_r7_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !ack_n |=> $stable(ncode));

  // R4: active level line is pending next cycle
  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_s & lvl)) |=> ((pend & $past(in_s & lvl)) == $past(in_s & lvl)));

  // R5: pending write keeps active level lines
  a_r5_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_rd && (bus_addr == A_PEND) |=>
      ((pend & $past(in_s & lvl & pend)) == $past(in_s & lvl & pend)));
endmodule

bind irq_hub irq_hub_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_req(irq_req),
  .fiq_req(fiq_req), .ncode(ncode), .pend(pend_q), .in_s(in_s), .lvl(lvl_vec)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_req, fiq_req;

  int n_chk = 0;
  int n_fail = 0;

  logic [4:0]  m_prio [32];
  logic [31:0] m_lvl, m_fast, m_mask, m_pend;

  always #2 clk = ~clk;

  irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_in = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_code(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int winner(input logic [31:0] cand);
    int w = -1;
    logic [4:0] best = '1;
    for (int i = 0; i < 32; i++)
      if (cand[i] && (w < 0 || m_prio[i] <= best)) begin
        w = i; best = m_prio[i];
      end
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    peek(8'h00, v); check("R1 pending", v, 32'h0);
    peek(8'h04, v); check("R1 mask", v, 32'hFFFF_FFFF);
    peek(8'h40, v); check("R1 cfg line9", v, 32'h0);
    peek(8'h10, v); check("R1 ncode", v, 32'h0);
    check("R1 irq_req", {31'b0, irq_req}, 32'h0);
    check("R1 fiq_req", {31'b0, fiq_req}, 32'h0);

    // R2 cfg layout and zero reads
    wr(8'h40, 32'h4E);
    peek(8'h40, v); check("R2 cfg readback", v, 32'h4E);
    peek(8'h18, v); check("R2 ctrl reads 0", v, 32'h0);
    peek(8'h9C, v); check("R2 swset reads 0", v, 32'h0);
    peek(8'h08, v); check("R2 unmapped reads 0", v, 32'h0);

    // R10 synchronizer latency (line 4, edge)
    do_reset();
    @(negedge clk); irq_in[4] = 1'b1; bus_addr = 8'h00;
    @(negedge clk); @(negedge clk); #1 check("R10 not yet pending", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R10 pending at third edge", bus_rdata, 32'h10);

    // R3 edge sensing, R7, R8 edge clear
    do_reset();
    wr(8'h04, 32'h0);
    @(negedge clk); irq_in[3] = 1'b1; idle(6);
    peek(8'h00, v); check("R3 edge sets", v, 32'h8);
    check("R7 irq_req up", {31'b0, irq_req}, 32'h1);
    rd_code(8'h10, v); check("R8 code", v, 32'd3);
    peek(8'h00, v); check("R8 edge cleared by read", v, 32'h0);
    idle(4);
    peek(8'h00, v); check("R3 held input no reset", v, 32'h0);
    check("R7 req held until ack", {31'b0, irq_req}, 32'h1);
    wr(8'h18, 32'h1); idle(2);
    check("R7 ack drops", {31'b0, irq_req}, 32'h0);
    @(negedge clk); irq_in[3] = 1'b0; idle(5);
    @(negedge clk); irq_in[3] = 1'b1; idle(5);
    @(negedge clk); irq_in[3] = 1'b0; idle(6);
    peek(8'h00, v); check("R3 edge stays after removal", v, 32'h8);

    // R4/R5/R8 level
    do_reset();
    wr(8'h1C + 8'd24, 32'h2);
    wr(8'h04, 32'h0);
    @(negedge clk); irq_in[6] = 1'b1; idle(6);
    peek(8'h00, v); check("R4 level sets", v, 32'h40);
    wr(8'h00, 32'h0);
    peek(8'h00, v); check("R5 active level kept", v, 32'h40);
    rd_code(8'h10, v); check("R8 level code", v, 32'd6);
    peek(8'h00, v); check("R8 level not cleared by read", v, 32'h40);
    @(negedge clk); irq_in[6] = 1'b0; idle(6);
    peek(8'h00, v); check("R4 level clears on removal", v, 32'h0);

    // R6 arbitration
    do_reset();
    wr(8'h1C + 8'd8,   (32'd7 << 2) | 32'h2);
    wr(8'h1C + 8'd40,  (32'd3 << 2) | 32'h2);
    wr(8'h1C + 8'd80,  (32'd3 << 2) | 32'h2);
    wr(8'h1C + 8'd100, (32'd1 << 2) | 32'h3);
    wr(8'h04, 32'h0);
    @(negedge clk); irq_in = 32'h0210_0404; idle(6);
    rd_code(8'h10, v); check("R6 tie goes to higher index", v, 32'd20);
    rd_code(8'h14, v); check("R6 fast path winner", v, 32'd25);
    check("R7 fiq_req up", {31'b0, fiq_req}, 32'h1);
    @(negedge clk); irq_in = 32'h0000_0404; idle(6);
    wr(8'h18, 32'h1); idle(3);
    rd_code(8'h10, v); check("R6 lower value wins", v, 32'd10);

    // R11 mask
    do_reset();
    wr(8'h1C + 8'd16, 32'h2);
    @(negedge clk); irq_in[4] = 1'b1; idle(6);
    check("R11 masked no request", {31'b0, irq_req}, 32'h0);
    wr(8'h04, ~32'h10); idle(2);
    check("R11 unmask raises request", {31'b0, irq_req}, 32'h1);
    rd_code(8'h10, v); check("R11 code", v, 32'd4);

    // R9 software set, R8 code write ignored
    do_reset();
    wr(8'h04, 32'h0);
    wr(8'h9C, 32'hA0);
    peek(8'h00, v); check("R9 only lowest bit", v, 32'h20);
    idle(2);
    check("R9 request from injection", {31'b0, irq_req}, 32'h1);
    wr(8'h10, 32'h1F);
    peek(8'h10, v); check("R8 code write ignored", v, 32'd5);

    // random rounds: R3 R4 R5 R6 R7 R8
    do_reset();
    for (int r = 0; r < 25; r++) begin
      int a, b, wn, wf;
      logic [31:0] vin, cfgw, cn, cf;
      a = int'($urandom % 32);
      b = (a + 1 + int'($urandom % 31)) % 32;
      for (int i = 0; i < 32; i++) begin
        m_prio[i] = 5'($urandom);
        m_lvl[i]  = 1'($urandom);
        m_fast[i] = 1'($urandom);
      end
      m_fast[a] = 1'b0; m_fast[b] = 1'b1;
      m_mask = $urandom; m_mask[a] = 1'b0; m_mask[b] = 1'b0;
      vin = $urandom; vin[a] = 1'b1; vin[b] = 1'b1;
      for (int i = 0; i < 32; i++) begin
        cfgw = {25'b0, m_prio[i], m_lvl[i], m_fast[i]};
        wr(8'h1C + 8'(4 * i), cfgw);
      end
      wr(8'h04, m_mask);
      @(negedge clk); irq_in = vin; idle(6);
      m_pend = vin;
      peek(8'h00, v); check("R3 R4 random pending", v, m_pend);
      wr(8'h18, 32'h3); idle(3);
      wn = winner(m_pend & ~m_mask & ~m_fast);
      wf = winner(m_pend & ~m_mask & m_fast);
      check("R7 random irq_req", {31'b0, irq_req}, 32'h1);
      check("R7 random fiq_req", {31'b0, fiq_req}, 32'h1);
      rd_code(8'h10, cn); check("R6 random normal winner", cn, 32'(wn));
      if (!m_lvl[wn]) m_pend[wn] = 1'b0;
      rd_code(8'h14, cf); check("R6 random fast winner", cf, 32'(wf));
      if (!m_lvl[wf]) m_pend[wf] = 1'b0;
      peek(8'h00, v); check("R8 random read clear", v, m_pend);
      @(negedge clk); irq_in = '0; idle(6);
      m_pend = m_pend & ~m_lvl;
      peek(8'h00, v); check("R3 R4 random removal", v, m_pend);
      wr(8'h00, 32'h0);
      peek(8'h00, v); check("R5 random clear", v, 32'h0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule